// File: doc/BRIEF.md
# Signed-Digit Radix-10 Multiplier Recoder

This block is purely combinational. It takes a multiplier operand of `DIGITS` packed BCD digits and rewrites it as `DIGITS+1` signed decimal digits, each in the range -5 to +5. Every signed digit is emitted as a six-bit select word: a one-hot group of five magnitude lines plus a sign line. A partial-product generator uses this word to pick one of the multiples 1X..5X of the multiplicand, or nothing, and to negate the choice when the sign is set. Because only five multiples are needed, the hard multiples of a plain radix-10 scheme (6X..9X) never have to be built.

Each digit of 5 or more is rewritten as (digit - 10), and +1 is carried into the next more significant position. Each digit adds the carry it receives from the digit below. The least significant digit receives no carry. The extra top position holds only the last carry. The block has no clock and no state. The naming and layout follow the project's state-machine conventions, but the block has no states or transitions to list.

Top module: `sdr10_recoder`

## Requirements
- R1: In every select word, at most one of the five magnitude lines is high.
- R2: Input digit k raises an outgoing carry exactly when it is 5 or more. Such a digit is recoded as (digit - 10). A digit of 0..4 is never given a negative recoded value.
- R3: Recoded digit k equals digit_k - 10*carry_k + carry_(k-1), where carry_(-1) = 0.
- R4: A recoded value of zero drives all five magnitude lines low and the sign line low. This includes input 9 with an incoming carry, which still carries out.
- R5: Word DIGITS (the top word) equals the carry out of input digit DIGITS-1. It is therefore 0 or +1, and never negative.
- R6: The sum over k of (signed digit k) * 10^k equals the decimal value of the BCD input.
- R7: Word k occupies sel_o[6k+5:6k]. Bit 6k+5 is the sign (1 = negative), and bit 6k+j-1 selects magnitude j, for j = 1..5. Input digit k occupies bcd_i[4k+3:4k].
- R8: Corner examples: input 0 with no incoming carry gives an all-zero word. Input 1 with an incoming carry gives +2. Input 5 with no incoming carry gives -5.
- R9: The block is correct for any DIGITS of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 4*DIGITS | Multiplier operand, packed BCD digits with the least significant digit in the low nibble |
| sel_o | output | 6*(DIGITS+1) | Signed-digit select words, one per recoded position |

## Verification
The bench builds two copies of the block. One uses the default of 16 digits, which allows long carry chains, runs of nines and the full 17-word output. The other uses a single digit, so the top word sits directly next to the least significant digit and every one of the ten input values can be applied exhaustively.

// File: rtl/sdr10_pkg.sv
package sdr10_pkg;
    localparam int BCD_W   = 4;
    localparam int MAG_N   = 5;
    localparam int WORD_W  = MAG_N + 1;
    localparam int SIGN_B  = MAG_N;
    localparam logic [BCD_W-1:0] SPLIT = 4'd5;
    localparam logic [BCD_W-1:0] RADIX = 4'd10;

    typedef logic [BCD_W-1:0]  bcd_t;
    typedef logic [WORD_W-1:0] sel_word_t;
    typedef logic [BCD_W-1:0]  mag_t;
endpackage

// File: rtl/sdr10_xfer.sv
module sdr10_xfer
    import sdr10_pkg::*;
(
    input  bcd_t digit_i,
    output logic xfer_o
);
    // A digit in the upper half is rewritten as digit-10 and carries one upward.
    always_comb begin
        xfer_o = (digit_i >= SPLIT);
    end
endmodule

// File: rtl/sdr10_onehot.sv
module sdr10_onehot
    import sdr10_pkg::*;
(
    input  mag_t             mag_i,
    output logic [MAG_N-1:0] hot_o
);
    for (genvar j = 1; j <= MAG_N; j++) begin : g_line
        localparam mag_t LEVEL = mag_t'(j);
        assign hot_o[j-1] = (mag_i == LEVEL);
    end
endmodule

// File: rtl/sdr10_digit.sv
module sdr10_digit
    import sdr10_pkg::*;
(
    input  bcd_t      digit_i,
    input  logic      xin_i,
    output sel_word_t word_o,
    output logic      xout_o
);
    logic             xout;
    mag_t             up_mag;
    mag_t             down_mag;
    mag_t             mag;
    logic [MAG_N-1:0] hot;

    sdr10_xfer u_xfer (
        .digit_i (digit_i),
        .xfer_o  (xout)
    );

    always_comb begin
        up_mag   = digit_i + mag_t'(xin_i);
        down_mag = RADIX - digit_i - mag_t'(xin_i);
        mag      = xout ? down_mag : up_mag;
    end

    sdr10_onehot u_hot (
        .mag_i (mag),
        .hot_o (hot)
    );

    always_comb begin
        word_o[MAG_N-1:0] = hot;
        word_o[SIGN_B]    = xout & (|hot);
        xout_o            = xout;
    end
endmodule

// File: rtl/sdr10_recoder.sv
module sdr10_recoder
    import sdr10_pkg::*;
#(
    parameter int DIGITS = 16
) (
    input  logic [BCD_W*DIGITS-1:0]      bcd_i,
    output logic [WORD_W*(DIGITS+1)-1:0] sel_o
);
    localparam int TOP = DIGITS;

    logic [DIGITS:0] xfer;

    assign xfer[0] = 1'b0;

    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
        sdr10_digit u_dig (
            .digit_i (bcd_i[BCD_W*k +: BCD_W]),
            .xin_i   (xfer[k]),
            .word_o  (sel_o[WORD_W*k +: WORD_W]),
            .xout_o  (xfer[k+1])
        );
    end

    // The top position only ever holds the final carry: +1 or nothing.
    assign sel_o[WORD_W*TOP +: WORD_W] = {1'b0, {(MAG_N-1){1'b0}}, xfer[DIGITS]};
endmodule

// File: rtl/sdr10_recoder_chk.sv
module sdr10_recoder_chk
    import sdr10_pkg::*;
#(
    parameter int DIGITS = 16
) (
    input logic [BCD_W*DIGITS-1:0]      bcd_i,
    input logic [WORD_W*(DIGITS+1)-1:0] sel_o
);
    for (genvar k = 0; k < DIGITS; k++) begin : g_chk
        always_comb begin
            if (!$isunknown(bcd_i)) begin
                p_onehot_mag_r1: assert ($onehot0(sel_o[WORD_W*k +: MAG_N]));
                p_zero_unsigned_r4: assert ((|sel_o[WORD_W*k +: MAG_N]) || !sel_o[WORD_W*k+SIGN_B]);
                p_low_half_pos_r2: assert ((bcd_i[BCD_W*k +: BCD_W] >= SPLIT) || !sel_o[WORD_W*k+SIGN_B]);
            end
        end
    end

    always_comb begin
        if (!$isunknown(bcd_i)) begin
            p_lsb_zero_r3: assert ((bcd_i[BCD_W-1:0] != '0) || (sel_o[WORD_W-1:0] == '0));
            p_top_nonneg_r5: assert (!sel_o[WORD_W*DIGITS+SIGN_B]
                                     && (sel_o[WORD_W*DIGITS+1 +: MAG_N-1] == '0));
            p_top_xfer_r5: assert (sel_o[WORD_W*DIGITS]
                                   == (bcd_i[BCD_W*(DIGITS-1) +: BCD_W] >= SPLIT));
        end
    end
endmodule

bind sdr10_recoder sdr10_recoder_chk #(.DIGITS(DIGITS)) u_chk (
    .bcd_i (bcd_i),
    .sel_o (sel_o)
);

// File: tb/sdr10_recoder_tb_top.sv
module sdr10_recoder_tb_top;
    localparam int D = 16;

    logic clk = 1'b0;
    always #5ns clk = ~clk;
    logic rst;

    logic [4*D-1:0]     bcd;
    logic [6*(D+1)-1:0] sel;
    logic [3:0]         bcd1;
    logic [11:0]        sel1;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    sdr10_recoder #(.DIGITS(D)) dut_i     (.bcd_i(bcd),  .sel_o(sel));
    sdr10_recoder #(.DIGITS(1)) dut_one_i (.bcd_i(bcd1), .sel_o(sel1));

    // Reference: expected select words from the recoding rule, positional.
    function automatic logic [6*(D+1)-1:0] ref_sel(input logic [4*D-1:0] b, input int n);
        logic [6*(D+1)-1:0] w = '0;
        int tin = 0;
        for (int k = 0; k < n; k++) begin
            int x = int'(b[4*k +: 4]);
            int t = (x >= 5) ? 1 : 0;
            int v = x - 10*t + tin;
            int m = (v < 0) ? -v : v;
            if (m > 0) w[6*k + m - 1] = 1'b1;
            if (v < 0) w[6*k + 5] = 1'b1;
            tin = t;
        end
        if (tin != 0) w[6*n] = 1'b1;
        return w;
    endfunction

    function automatic longint bcd_val(input logic [4*D-1:0] b, input int n);
        longint s = 0;
        for (int k = n - 1; k >= 0; k--) s = s*10 + longint'(b[4*k +: 4]);
        return s;
    endfunction

    function automatic longint sd_val(input logic [6*(D+1)-1:0] w, input int n);
        longint s = 0;
        for (int k = n; k >= 0; k--) begin
            longint dv = 0;
            for (int j = 1; j <= 5; j++) if (w[6*k + j - 1]) dv = longint'(j);
            if (w[6*k + 5]) dv = -dv;
            s = s*10 + dv;
        end
        return s;
    endfunction

    task automatic judge(input bit ok, input string req, input longint act, input longint exp_v);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check_all(input logic [6*(D+1)-1:0] w, input logic [4*D-1:0] b, input int n);
        logic [6*(D+1)-1:0] e = ref_sel(b, n);
        int hot_bad = 0;
        int zs_bad  = 0;
        for (int k = 0; k <= n; k++) begin
            if ($countones(w[6*k +: 5]) > 1) hot_bad++;
            if (w[6*k +: 5] == 5'b0 && w[6*k + 5]) zs_bad++;
        end
        judge(w == e, "R3/R7 words", longint'(w[63:0]), longint'(e[63:0]));
        judge(sd_val(w, n) == bcd_val(b, n), "R6 weighted sum", sd_val(w, n), bcd_val(b, n));
        judge(hot_bad == 0, "R1 one-hot", hot_bad, 0);
        judge(zs_bad == 0, "R4 zero unsigned", zs_bad, 0);
        judge(w[6*n +: 6] == e[6*n +: 6] && !w[6*n + 5], "R5 top word",
              longint'(w[6*n +: 6]), longint'(e[6*n +: 6]));
    endtask

    task automatic apply(input logic [4*D-1:0] b);
        @(posedge clk);
        bcd <= b;
        @(negedge clk);
        check_all(sel, bcd, D);
    endtask

    task automatic apply_one(input logic [3:0] b);
        logic [6*(D+1)-1:0] w = '0;
        @(posedge clk);
        bcd1 <= b;
        @(negedge clk);
        w[11:0] = sel1;
        check_all(w, {{(4*D-4){1'b0}}, bcd1}, 1);
    endtask

    function automatic logic [4*D-1:0] rnd_bcd();
        logic [4*D-1:0] b;
        for (int k = 0; k < D; k++) b[4*k +: 4] = 4'($urandom_range(9, 0));
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        bcd  = '0;
        bcd1 = '0;
        repeat (3) @(posedge clk);
        // Reset-state check: all-zero operand recodes to all-zero words (R4, R8).
        @(negedge clk);
        judge(sel == '0, "R8 zero input", longint'(sel[63:0]), 0);
        rst = 1'b0;

        apply('0);
        apply({D{4'h9}});
        apply({D{4'h5}});
        apply({D{4'h4}});
        apply({{(D-2){4'h0}}, 4'h1, 4'h5});
        // R8: digit1 = 1 with carry gives +2; digit0 = 5 gives -5.
        @(negedge clk);
        judge(sel[11:0] == {6'b000010, 6'b110000}, "R8 corner words",
              longint'(sel[11:0]), longint'({6'b000010, 6'b110000}));
        apply({4'h9, {(D-1){4'h0}}});
        apply({4'h4, {(D-1){4'h9}}});
        apply({{(D-1){4'h0}}, 4'h9});
        for (int i = 0; i < 300; i++) apply(rnd_bcd());
        // R9: single-digit build, exhaustive.
        for (int v = 0; v < 10; v++) apply_one(4'(v));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule